// File: doc/BRIEF.md
# Memory Traffic Command Generator

This block produces an endless stream of memory commands for stressing a memory port. Each command has a byte address, a burst length between 1 and 64, and a one-bit operation code (write or read). The stream goes to a downstream controller over a valid/ready handshake. A command stays on the outputs until the controller accepts it.

Each of the three command fields has its own run-time selector, so the fields can be generated in different ways at once. A field can be copied from a fixed-value input. The address can also step through a window. Any field can instead come from a 32-stage pseudo-random register.

Random addresses are kept inside the port's window by two bitwise masks rather than by division. Where the lower mask holds a 1, the address bit is ANDed with the window end. Where the upper mask holds a 1, the address bit is ORed with the window start.

Top module: `mem_cmd_gen`

## Requirements
- R1: While `rst_n` is low, `cmd_valid` is 0. On the first rising clock edge after `rst_n` goes high, the first command is loaded and `cmd_valid` becomes 1. From then on `cmd_valid` stays 1.
- R2: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_addr`, `cmd_len` and `cmd_op` hold their values. This holds even when the selectors or the fixed inputs change.
- R3: A new command is loaded only at an edge where `cmd_valid` and `cmd_ready` are both 1, or at the first edge after reset. The selectors and inputs present at that edge decide the fields of the new command.
- R4: Selector encoding, used for `addr_sel`, `len_sel` and `op_sel`: 0 = fixed, 1 = sequential, 2 = random, 3 = fixed. Sequential has a meaning only for the address; for length and operation, 1 acts as fixed. In fixed mode the field is copied from `fixed_addr`, `fixed_len` or `fixed_op`. Each selector acts on its own field only.
- R5: A fixed length of 0 is issued as 1. A fixed length above 64 is issued as 64. Lengths 1 to 64 pass through unchanged.
- R6: In sequential address mode, each command issued in that mode takes the counter's address and then advances the counter by `PORT_BYTES`. The counter is `WIN_START` after reset. It does not move for commands issued in other address modes.
- R7: If the advanced address would exceed the effective window end, the counter returns to `WIN_START` instead.
- R8: The effective window end is `WIN_END` with bits [3:0] cleared. This value is used both for the wrap test and for the AND fold.
- R9: The random source is a 32-bit register. Each step shifts it left and inserts, as the new bit 0, the XOR of bits 31, 21, 1 and 0. Its first value is `lfsr_seed`, sampled at the first edge after reset. A zero seed is replaced by 0x5EED0001. The source steps once for every loaded command, in any mode.
- R10: In random address mode, the address is the current random value folded in two stages. First, bits where `AND_MASK` is 1 are ANDed with the effective window end. Then bits where `OR_MASK` is 1 are ORed with `WIN_START`.
- R11: In random mode the length is random bits [13:8], with 0 mapped to 1. The operation is random bit 16. Operation encoding: 0 = write, 1 = read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| addr_sel | input | 2 | Address generation selector |
| len_sel | input | 2 | Burst length generation selector |
| op_sel | input | 2 | Operation generation selector |
| fixed_addr | input | ADDR_W | Address used in fixed address mode |
| fixed_len | input | 7 | Length used in fixed length mode (clamped to 1..64) |
| fixed_op | input | 1 | Operation used in fixed operation mode |
| lfsr_seed | input | 32 | Seed of the random source |
| cmd_valid | output | 1 | A command is presented |
| cmd_ready | input | 1 | The controller accepts the presented command |
| cmd_addr | output | ADDR_W | Command byte address |
| cmd_len | output | 7 | Command burst length, 1..64 |
| cmd_op | output | 1 | Command operation, 0 write, 1 read |

## Verification
Two pairs of functions share a cycle.

First, the edge that loads the seed into the random source also builds the first command from that seed. Two resets cover this: one with a nonzero seed and one with a zero seed. The first accepted command in each is compared against values computed from the seed.

Second, the sequential counter's wrap lands on an accepting edge. A stall on the controller's side can also coincide with a change of the selectors. These are provoked by running more sequential commands than the window holds, with the ready line stalling every third cycle. The selectors are changed only while a command is held. Every accepted command is compared against a queue built from the requirements, and every stalled cycle is checked against the previous one.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED = 2'd0,
    MODE_SEQ   = 2'd1,
    MODE_RAND  = 2'd2,
    MODE_ALT   = 2'd3
  } gen_mode_e;

  localparam int unsigned LFSR_W = 32;
  localparam logic [LFSR_W-1:0] SEED_SUBST = 32'h5EED_0001;

  // Fibonacci step, taps 32, 22, 2, 1
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/mcg_lfsr.sv
module mcg_lfsr
  import mcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              primed,
  input  logic [LFSR_W-1:0] seed,
  output logic [LFSR_W-1:0] cur
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_d;
  logic [LFSR_W-1:0] seed_fix;

  always_comb begin
    seed_fix = (seed == '0) ? SEED_SUBST : seed;
    cur      = primed ? state_q : seed_fix;
    state_d  = step_en ? lfsr_advance(cur) : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED_SUBST;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/mcg_seq_addr.sv
module mcg_seq_addr #(
  parameter int unsigned          ADDR_W     = 32,
  parameter int unsigned          PORT_BYTES = 8,
  parameter logic [ADDR_W-1:0]    WIN_START  = '0,
  parameter logic [ADDR_W-1:0]    WIN_END    = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              advance,
  input  logic              primed,
  output logic [ADDR_W-1:0] cur
);

  localparam logic [ADDR_W-1:0] END_EFF = WIN_END & ~ADDR_W'(15);
  localparam logic [ADDR_W:0]   STEP    = (ADDR_W+1)'(PORT_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W:0]   bumped;
  logic              wraps;

  always_comb begin
    cur    = primed ? addr_q : WIN_START;
    bumped = {1'b0, cur} + STEP;
    wraps  = bumped > {1'b0, END_EFF};
    addr_d = addr_q;
    if (step_en) begin
      if (advance) addr_d = wraps ? WIN_START : bumped[ADDR_W-1:0];
      else         addr_d = cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= WIN_START;
    else        addr_q <= addr_d;
  end

endmodule

// File: rtl/mcg_field_sel.sv
module mcg_field_sel
  import mcg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       BL_MAX    = 64,
  parameter logic [ADDR_W-1:0] WIN_START = '0,
  parameter logic [ADDR_W-1:0] WIN_END   = '1,
  parameter logic [ADDR_W-1:0] AND_MASK  = '0,
  parameter logic [ADDR_W-1:0] OR_MASK   = '0,
  localparam int unsigned      BL_W      = $clog2(BL_MAX + 1)
) (
  input  logic [1:0]        addr_sel,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        op_sel,
  input  logic [ADDR_W-1:0] fixed_addr,
  input  logic [BL_W-1:0]   fixed_len,
  input  logic              fixed_op,
  input  logic [LFSR_W-1:0] rnd,
  input  logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] addr,
  output logic [BL_W-1:0]   len,
  output logic              op
);

  localparam logic [ADDR_W-1:0] END_EFF = WIN_END & ~ADDR_W'(15);
  localparam int unsigned       RBL_W   = $clog2(BL_MAX);
  localparam int unsigned       RBL_LSB = 8;
  localparam int unsigned       OP_BIT  = 16;

  logic [ADDR_W-1:0] raw_addr;
  logic [ADDR_W-1:0] folded;
  logic [RBL_W-1:0]  rnd_len;
  logic [BL_W-1:0]   clamp_len;

  always_comb begin
    raw_addr = rnd[ADDR_W-1:0];
    folded   = (raw_addr & ~AND_MASK) | (raw_addr & END_EFF & AND_MASK);
    folded   = folded | (WIN_START & OR_MASK);
    rnd_len  = rnd[RBL_LSB +: RBL_W];

    if (fixed_len == '0)                clamp_len = BL_W'(1);
    else if (fixed_len > BL_W'(BL_MAX)) clamp_len = BL_W'(BL_MAX);
    else                                clamp_len = fixed_len;

    case (gen_mode_e'(addr_sel))
      MODE_SEQ:  addr = seq_addr;
      MODE_RAND: addr = folded;
      default:   addr = fixed_addr;
    endcase

    if (gen_mode_e'(len_sel) == MODE_RAND)
      len = (rnd_len == '0) ? BL_W'(1) : BL_W'(rnd_len);
    else
      len = clamp_len;

    op = (gen_mode_e'(op_sel) == MODE_RAND) ? rnd[OP_BIT] : fixed_op;
  end

endmodule

// File: rtl/mem_cmd_gen.sv
module mem_cmd_gen
  import mcg_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       BL_MAX     = 64,
  parameter int unsigned       PORT_BYTES = 8,
  parameter logic [ADDR_W-1:0] WIN_START  = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] WIN_END    = 32'h0000_10FC,
  parameter logic [ADDR_W-1:0] AND_MASK   = 32'hFFFF_FF00,
  parameter logic [ADDR_W-1:0] OR_MASK    = 32'h0000_1000,
  localparam int unsigned      BL_W       = $clog2(BL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr_sel,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        op_sel,
  input  logic [ADDR_W-1:0] fixed_addr,
  input  logic [BL_W-1:0]   fixed_len,
  input  logic              fixed_op,
  input  logic [31:0]       lfsr_seed,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BL_W-1:0]   cmd_len,
  output logic              cmd_op
);

  logic              valid_q;
  logic              load;
  logic [LFSR_W-1:0] rnd_cur;
  logic [ADDR_W-1:0] seq_cur;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BL_W-1:0]   nxt_len;
  logic              nxt_op;
  logic [ADDR_W-1:0] addr_q;
  logic [BL_W-1:0]   len_q;
  logic              op_q;

  // R3: load on the first edge after reset or on an accepted command
  always_comb load = !valid_q || cmd_ready;

  mcg_lfsr u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (load),
    .primed  (valid_q),
    .seed    (lfsr_seed),
    .cur     (rnd_cur)
  );

  mcg_seq_addr #(
    .ADDR_W     (ADDR_W),
    .PORT_BYTES (PORT_BYTES),
    .WIN_START  (WIN_START),
    .WIN_END    (WIN_END)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (load),
    .advance (gen_mode_e'(addr_sel) == MODE_SEQ),
    .primed  (valid_q),
    .cur     (seq_cur)
  );

  mcg_field_sel #(
    .ADDR_W    (ADDR_W),
    .BL_MAX    (BL_MAX),
    .WIN_START (WIN_START),
    .WIN_END   (WIN_END),
    .AND_MASK  (AND_MASK),
    .OR_MASK   (OR_MASK)
  ) u_sel (
    .addr_sel   (addr_sel),
    .len_sel    (len_sel),
    .op_sel     (op_sel),
    .fixed_addr (fixed_addr),
    .fixed_len  (fixed_len),
    .fixed_op   (fixed_op),
    .rnd        (rnd_cur),
    .seq_addr   (seq_cur),
    .addr       (nxt_addr),
    .len        (nxt_len),
    .op         (nxt_op)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      len_q   <= BL_W'(1);
      op_q    <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      addr_q  <= nxt_addr;
      len_q   <= nxt_len;
      op_q    <= nxt_op;
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_addr  = addr_q;
  assign cmd_len   = len_q;
  assign cmd_op    = op_q;

endmodule

// File: rtl/mcg_checker.sv
module mcg_checker
  import mcg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       BL_MAX    = 64,
  parameter logic [ADDR_W-1:0] WIN_START = '0,
  parameter logic [ADDR_W-1:0] WIN_END   = '1,
  parameter logic [ADDR_W-1:0] AND_MASK  = '0,
  parameter logic [ADDR_W-1:0] OR_MASK   = '0,
  localparam int unsigned      BL_W      = $clog2(BL_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        addr_sel,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [BL_W-1:0]   cmd_len,
  input logic              cmd_op
);

  localparam logic [ADDR_W-1:0] END_EFF  = WIN_END & ~ADDR_W'(15);
  localparam logic [ADDR_W-1:0] ZERO_BIT = AND_MASK & ~END_EFF;
  localparam logic [ADDR_W-1:0] ONE_BIT  = OR_MASK & WIN_START;

  p_first_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> cmd_valid);

  p_valid_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid);

  p_fields_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_op));

  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len >= BL_W'(1)) && (cmd_len <= BL_W'(BL_MAX)));

  p_rand_fold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_ready) && gen_mode_e'(addr_sel) == MODE_RAND |=>
      ((cmd_addr & ZERO_BIT) == '0) && ((cmd_addr & ONE_BIT) == ONE_BIT));

endmodule

bind mem_cmd_gen mcg_checker #(
  .ADDR_W    (ADDR_W),
  .BL_MAX    (BL_MAX),
  .WIN_START (WIN_START),
  .WIN_END   (WIN_END),
  .AND_MASK  (AND_MASK),
  .OR_MASK   (OR_MASK)
) u_mcg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_sel  (addr_sel),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .cmd_len   (cmd_len),
  .cmd_op    (cmd_op)
);

// File: tb/test_mem_cmd_gen.sv
module test_mem_cmd_gen;

  localparam logic [31:0] START = 32'h0000_1000;
  localparam logic [31:0] WEND  = 32'h0000_10FC;
  localparam logic [31:0] AMASK = 32'hFFFF_FF00;
  localparam logic [31:0] OMASK = 32'h0000_1000;
  localparam int          STEPB = 8;
  localparam logic [31:0] EEFF  = WEND & 32'hFFFF_FFF0;

  logic        clk;
  logic        rst_n;
  logic [1:0]  addr_sel, len_sel, op_sel;
  logic [31:0] fixed_addr;
  logic [6:0]  fixed_len;
  logic        fixed_op;
  logic [31:0] lfsr_seed;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_addr;
  logic [6:0]  cmd_len;
  logic        cmd_op;

  int checks = 0;
  int fails  = 0;
  int hs_count = 0;

  logic [31:0] q_addr[$];
  logic [6:0]  q_len[$];
  logic        q_op[$];
  string       q_tag[$];

  logic [31:0] m_lfsr, m_seq;
  bit          m_started;

  mem_cmd_gen #(
    .ADDR_W(32), .BL_MAX(64), .PORT_BYTES(STEPB),
    .WIN_START(START), .WIN_END(WEND), .AND_MASK(AMASK), .OR_MASK(OMASK)
  ) i_mem_cmd_gen (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .len_sel(len_sel),
    .op_sel(op_sel), .fixed_addr(fixed_addr), .fixed_len(fixed_len),
    .fixed_op(fixed_op), .lfsr_seed(lfsr_seed), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_op(cmd_op)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] step_r9(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic model_reset();
    m_started = 0;
    m_lfsr = 32'h0;
    m_seq = START;
  endtask

  // Push the command that the next load will produce with current inputs
  task automatic model_load(input string tag);
    logic [31:0] r, s, a, nx;
    logic [6:0]  l;
    logic        o;
    r = m_started ? m_lfsr : ((lfsr_seed == 0) ? 32'h5EED_0001 : lfsr_seed);
    s = m_started ? m_seq : START;
    case (addr_sel)
      2'd1: a = s;
      2'd2: a = ((r & ~AMASK) | (r & EEFF & AMASK)) | (START & OMASK);
      default: a = fixed_addr;
    endcase
    if (len_sel == 2'd2) l = (r[13:8] == 0) ? 7'd1 : {1'b0, r[13:8]};
    else if (fixed_len == 0) l = 7'd1;
    else if (fixed_len > 7'd64) l = 7'd64;
    else l = fixed_len;
    o = (op_sel == 2'd2) ? r[16] : fixed_op;
    if (addr_sel == 2'd1) begin
      nx = s + STEPB;
      m_seq = (nx > EEFF) ? START : nx;
    end else m_seq = s;
    m_lfsr = step_r9(r);
    m_started = 1;
    q_addr.push_back(a); q_len.push_back(l); q_op.push_back(o); q_tag.push_back(tag);
  endtask

  function automatic string fmt(input logic [31:0] a, input logic [6:0] l, input logic o);
    return $sformatf("{addr=%h len=%0d op=%0b}", a, l, o);
  endfunction

  task automatic compare_head();
    logic [31:0] ea; logic [6:0] el; logic eo; string t;
    if (q_addr.size() == 0) begin
      check(0, "R3", "unexpected command", "empty queue");
      return;
    end
    ea = q_addr.pop_front(); el = q_len.pop_front(); eo = q_op.pop_front(); t = q_tag.pop_front();
    check(cmd_addr == ea && cmd_len == el && cmd_op == eo, t,
          fmt(cmd_addr, cmd_len, cmd_op), fmt(ea, el, eo));
  endtask

  // Monitor: samples 2 ns after the falling edge
  bit          have_hold = 0;
  logic [31:0] h_addr; logic [6:0] h_len; logic h_op;
  always @(negedge clk) begin
    #2;
    if (!rst_n) have_hold = 0;
    else if (cmd_valid) begin
      if (have_hold)
        check(cmd_addr == h_addr && cmd_len == h_len && cmd_op == h_op, "R2",
              fmt(cmd_addr, cmd_len, cmd_op), fmt(h_addr, h_len, h_op));
      if (cmd_ready) begin
        compare_head();
        hs_count++;
        have_hold = 0;
      end else begin
        h_addr = cmd_addr; h_len = cmd_len; h_op = cmd_op;
        have_hold = 1;
      end
    end
  end

  // Driver: predict n loads, then grant n handshakes
  task automatic run(input int n, input bit stall, input string tag);
    int target, cyc;
    for (int k = 0; k < n; k++) model_load(tag);
    target = hs_count + n;
    cyc = 0;
    @(negedge clk);
    while (hs_count < target) begin
      cmd_ready = stall ? (cyc % 3 != 2) : 1'b1;
      cyc++;
      @(negedge clk);
    end
    cmd_ready = 1'b0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    cmd_ready = 1'b0;
    q_addr.delete(); q_len.delete(); q_op.delete(); q_tag.delete();
    model_reset();
    repeat (3) @(negedge clk);
    #2;
    check(cmd_valid == 1'b0, "R1", $sformatf("%0b", cmd_valid), "0");
    model_load(tag);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(cmd_valid == 1'b1, "R1", $sformatf("%0b", cmd_valid), "1");
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_ready = 1'b0;
    addr_sel = 2'd0; len_sel = 2'd0; op_sel = 2'd0;
    fixed_addr = 32'h1234_5670; fixed_len = 7'd0; fixed_op = 1'b0;
    lfsr_seed = 32'hC0DE_1357;

    // R1 R5 reset and first load: fixed length 0 becomes 1
    do_reset("R5");
    // R4 fixed fields, with stalls (R2)
    fixed_addr = 32'hDEAD_BEE0; fixed_len = 7'd5; fixed_op = 1'b1;
    run(4, 1, "R4");
    fixed_len = 7'd100; run(2, 0, "R5");
    fixed_len = 7'd64;  fixed_op = 1'b0; run(2, 0, "R5");
    // R6 R7 R8 sequential past the window end, stalling
    addr_sel = 2'd1; fixed_len = 7'd16;
    run(36, 1, "R7");
    // R9 R10 R11 all random
    addr_sel = 2'd2; len_sel = 2'd2; op_sel = 2'd2;
    run(24, 1, "R10");
    // R4 independent selectors and encoding 3; sequential counter resumes (R6)
    addr_sel = 2'd3; len_sel = 2'd2; op_sel = 2'd1; fixed_op = 1'b1; fixed_addr = 32'h0000_0040;
    run(4, 0, "R4");
    addr_sel = 2'd1; len_sel = 2'd1; op_sel = 2'd2; fixed_len = 7'd1;
    run(6, 1, "R6");
    // R3: stalled, selectors change, then held command still checked
    addr_sel = 2'd0; len_sel = 2'd0; op_sel = 2'd0;
    repeat (3) @(negedge clk);
    run(3, 0, "R3");
    #2; compare_head();
    // R9 zero seed replaced by the constant
    addr_sel = 2'd2; len_sel = 2'd2; op_sel = 2'd2; lfsr_seed = 32'h0;
    do_reset("R9");
    run(10, 0, "R9");
    #2; compare_head();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule